// File: doc/BRIEF.md
# PHY Test-Register Write Port

This block receives a 24-bit control word that software updates through a single system-controller register, and turns it into byte writes to a small register file inside a USB 2.0 PHY. The word packs a data byte, a register address, a port number, a write enable, a test-clock bit that software toggles by hand, and an active-low test reset. Because the test clock is only a bit in a register, the block samples the whole word in its own clock domain and detects the rising edge of that bit synchronously.

Software performs one write as three updates of the word. First it places the fields with the test clock low. Then it raises the test clock. Then it lowers the test clock again. The block stores the data byte in the addressed register of the selected port on the rising edge only. Every register is driven out as a flat vector. The PHY clock enable, bit 2 of register 6 in port 0, also gets its own output pin.

Top module: `phy_tstreg_port`

## Requirements
- R1: After the system reset `rstN` is released, every register reads zero on `regFlat` and `phyClkEn` is 0.
- R2: Control word layout: data in bits 7:0, address in bits 15:8, port in bits 18:16, write enable in bit 21, test clock in bit 22, active-low test reset in bit 23. When the word with bit 22 at 1 is first presented, the data byte shows up at `regFlat[(port*REG_COUNT+addr)*8 +: 8]` exactly three rising edges of `clk` later, and not before.
- R3: A write happens only on a 0-to-1 transition of bit 22. While bit 22 stays high, changes to the data field do not reach any register.
- R4: A test-clock rising edge while bit 21 is 0 changes no register.
- R5: While bit 23 is 0, no write is accepted and all registers are cleared to zero.
- R6: A port number of NUM_PORTS (2) or more changes no register.
- R7: An address of REG_COUNT (16) or more changes no register.
- R8: `phyClkEn` equals bit 2 of register address 6 in port 0.
- R9: Ports are independent. A write to one port leaves the other port's registers unchanged, including address 6 of port 1 with respect to `phyClkEn`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock used to sample the control word |
| rstN | input | 1 | Active-low system reset |
| ctrlWord | input | 24 | Software-driven control word |
| regFlat | output | NUM_PORTS*REG_COUNT*8 | All registers, port-major, byte per address |
| phyClkEn | output | 1 | PHY clock enable from port 0, address 6, bit 2 |

## Verification
The write-landing assertion assumes that the port, address and data fields are already stable when the test-clock bit rises. Because of this, the captured fields are the ones that software meant to write. The bench always keeps to the three-step sequence and holds each word for four clock cycles. This lets the two-stage sampler settle before the next field change. The one deliberate break, where the data changes while the clock bit is held high, occurs only after the edge has already been consumed, so the assumption still holds.

// File: rtl/phy_tstreg_pkg.sv
package phy_tstreg_pkg;

  localparam int WORD_W      = 24;
  localparam int DATA_W      = 8;
  localparam int CLK_REG_ADR = 6;
  localparam int CLK_EN_BIT  = 2;

  // Field layout of the software control word (bit 23 down to bit 0).
  typedef struct packed {
    logic              tstRstN;  // 23
    logic              tstClk;   // 22
    logic              wrEn;     // 21
    logic [1:0]        spare;    // 20:19
    logic [2:0]        port;     // 18:16
    logic [7:0]        addr;     // 15:8
    logic [DATA_W-1:0] data;     // 7:0
  } ctlWord_t;

  // Strobes from control to datapath.
  typedef struct packed {
    logic              wr;
    logic              clear;
    logic [2:0]        port;
    logic [7:0]        addr;
    logic [DATA_W-1:0] data;
  } tstStrobe_t;

endpackage

// File: rtl/phy_tstreg_ctrl.sv
module phy_tstreg_ctrl
  import phy_tstreg_pkg::*;
#(
  parameter int NUM_PORTS = 2,
  parameter int REG_COUNT = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [WORD_W-1:0]   ctrlWord,
  output tstStrobe_t          strobe
);

  ctlWord_t stage1, stage2;
  logic     tclkPrev;
  logic     tclkRise, inRange;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage1   <= '0;
      stage2   <= '0;
      tclkPrev <= 1'b0;
    end else begin
      stage1   <= ctlWord_t'(ctrlWord);
      stage2   <= stage1;
      tclkPrev <= stage2.tstClk;
    end
  end

  always_comb begin
    tclkRise     = stage2.tstClk && !tclkPrev;
    inRange      = (int'(stage2.port) < NUM_PORTS) && (int'(stage2.addr) < REG_COUNT);
    strobe.clear = !stage2.tstRstN;
    strobe.wr    = tclkRise && stage2.wrEn && stage2.tstRstN && inRange;
    strobe.port  = stage2.port;
    strobe.addr  = stage2.addr;
    strobe.data  = stage2.data;
  end

  // A write always traces back to the clock bit being high at the input two edges earlier.
  AST_WR_FROM_CLKBIT: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wr |-> $past(ctrlWord[22], 2)) else $error("write without clock bit"); // R3
  // One rising edge yields one write only.
  AST_SINGLE_SHOT: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wr |=> !strobe.wr) else $error("repeated write"); // R3

endmodule

// File: rtl/phy_tstreg_dp.sv
module phy_tstreg_dp
  import phy_tstreg_pkg::*;
#(
  parameter int NUM_PORTS = 2,
  parameter int REG_COUNT = 16
) (
  input  logic                                clk,
  input  logic                                rstN,
  input  tstStrobe_t                          strobe,
  output logic [NUM_PORTS*REG_COUNT*DATA_W-1:0] regFlat
);

  localparam int TOTAL = NUM_PORTS * REG_COUNT;

  logic [DATA_W-1:0] regFile [TOTAL];

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    for (genvar a = 0; a < REG_COUNT; a++) begin : g_reg
      localparam int IDX = p * REG_COUNT + a;
      logic hit;
      assign hit = strobe.wr && (int'(strobe.port) == p) && (int'(strobe.addr) == a);

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)             regFile[IDX] <= '0;
        else if (strobe.clear) regFile[IDX] <= '0;
        else if (hit)          regFile[IDX] <= strobe.data;
      end

      assign regFlat[IDX*DATA_W +: DATA_W] = regFile[IDX];
    end
  end

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wr |=> regFlat[(int'($past(strobe.port))*REG_COUNT + int'($past(strobe.addr)))*DATA_W +: DATA_W]
                  == $past(strobe.data)) else $error("write lost"); // R2
  AST_CLEAR_ALL: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clear |=> regFlat == '0) else $error("clear failed"); // R5
  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.wr && !strobe.clear) |=> $stable(regFlat)) else $error("spurious change"); // R4

endmodule

// File: rtl/phy_tstreg_port.sv
module phy_tstreg_port
  import phy_tstreg_pkg::*;
#(
  parameter int NUM_PORTS = 2,
  parameter int REG_COUNT = 16
) (
  input  logic                                  clk,
  input  logic                                  rstN,
  input  logic [WORD_W-1:0]                     ctrlWord,
  output logic [NUM_PORTS*REG_COUNT*DATA_W-1:0] regFlat,
  output logic                                  phyClkEn
);

  localparam int CLK_BIT_POS = CLK_REG_ADR * DATA_W + CLK_EN_BIT;

  tstStrobe_t strobe;

  phy_tstreg_ctrl #(.NUM_PORTS(NUM_PORTS), .REG_COUNT(REG_COUNT)) u_ctrl (
    .clk(clk), .rstN(rstN), .ctrlWord(ctrlWord), .strobe(strobe)
  );

  phy_tstreg_dp #(.NUM_PORTS(NUM_PORTS), .REG_COUNT(REG_COUNT)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .regFlat(regFlat)
  );

  assign phyClkEn = regFlat[CLK_BIT_POS];

  // The clock enable only rises when port 0 was written in the previous cycle.
  AST_CLKEN_SOURCE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(phyClkEn) |-> ($past(strobe.wr) && $past(strobe.port) == 3'd0
                         && $past(strobe.addr) == 8'(CLK_REG_ADR))) else $error("clk enable source"); // R8

endmodule

// File: tb/tb_phy_tstreg_port.sv
module tb_phy_tstreg_port;
  localparam int NP = 2;
  localparam int NR = 16;
  localparam int FW = NP * NR * 8;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [23:0]   ctrlWord = '0;
  logic [FW-1:0] regFlat;
  logic          phyClkEn;

  int nChecks = 0;
  int nFails  = 0;
  logic [7:0] model [NP*NR];

  always #2 clk = ~clk;

  phy_tstreg_port #(.NUM_PORTS(NP), .REG_COUNT(NR)) dut (
    .clk(clk), .rstN(rstN), .ctrlWord(ctrlWord), .regFlat(regFlat), .phyClkEn(phyClkEn)
  );

  // Table entries: {tstRstN, wrEn, port[2:0], addr[7:0], data[7:0]}
  localparam int NV = 10;
  localparam logic [20:0] VEC [NV] = '{
    {1'b1, 1'b1, 3'd0, 8'd6,  8'h04},  // R8 enable on
    {1'b1, 1'b1, 3'd1, 8'd3,  8'hA5},  // R2
    {1'b1, 1'b1, 3'd0, 8'd15, 8'h3C},  // R2
    {1'b1, 1'b1, 3'd1, 8'd6,  8'hFF},  // R9
    {1'b1, 1'b1, 3'd2, 8'd1,  8'h77},  // R6
    {1'b1, 1'b0, 3'd0, 8'd3,  8'h99},  // R4
    {1'b1, 1'b1, 3'd0, 8'd16, 8'h55},  // R7
    {1'b1, 1'b1, 3'd5, 8'd0,  8'h11},  // R6
    {1'b1, 1'b1, 3'd0, 8'd6,  8'h00},  // R8 enable off
    {1'b1, 1'b1, 3'd0, 8'd6,  8'h04}   // R8 enable on again
  };

  function automatic logic [FW-1:0] modelFlat();
    logic [FW-1:0] f;
    for (int i = 0; i < NP*NR; i++) f[i*8 +: 8] = model[i];
    return f;
  endfunction

  task automatic check(input string req, input logic [FW-1:0] act, input logic [FW-1:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic putWord(input logic [23:0] w, input int waitCycles);
    @(negedge clk);
    ctrlWord = w;
    repeat (waitCycles) @(negedge clk);
  endtask

  function automatic logic [23:0] mkWord(input logic rs, input logic ck, input logic we,
                                         input logic [2:0] p, input logic [7:0] a, input logic [7:0] d);
    return {rs, ck, we, 2'b00, p, a, d};
  endfunction

  task automatic applyModel(input logic rs, input logic we, input logic [2:0] p,
                            input logic [7:0] a, input logic [7:0] d);
    if (!rs) begin
      for (int i = 0; i < NP*NR; i++) model[i] = 8'h00;
    end else if (we && p < NP && a < NR) begin
      model[int'(p)*NR + int'(a)] = d;
    end
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin : stim
    for (int i = 0; i < NP*NR; i++) model[i] = 8'h00;
    ctrlWord = mkWord(1'b1, 1'b0, 1'b0, 3'd0, 8'd0, 8'd0);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 regs", regFlat, '0);
    check("R1 clken", FW'(phyClkEn), FW'(0));

    // R2 latency: visible at the third edge after the clock bit rises, not at the second
    putWord(mkWord(1'b1, 1'b0, 1'b1, 3'd1, 8'd9, 8'h5A), 4);
    @(negedge clk);
    ctrlWord = mkWord(1'b1, 1'b1, 1'b1, 3'd1, 8'd9, 8'h5A);
    repeat (2) @(negedge clk);
    check("R2 before", FW'(regFlat[(1*NR+9)*8 +: 8]), FW'(8'h00));
    @(negedge clk);
    check("R2 after", FW'(regFlat[(1*NR+9)*8 +: 8]), FW'(8'h5A));
    applyModel(1'b1, 1'b1, 3'd1, 8'd9, 8'h5A);
    putWord(mkWord(1'b1, 1'b0, 1'b1, 3'd1, 8'd9, 8'h5A), 4);

    // Table walk: three-step write, then compare everything
    for (int v = 0; v < NV; v++) begin
      logic rs, we;
      logic [2:0] p;
      logic [7:0] a, d;
      {rs, we, p, a, d} = VEC[v];
      putWord(mkWord(rs, 1'b0, we, p, a, d), 4);
      putWord(mkWord(rs, 1'b1, we, p, a, d), 4);
      putWord(mkWord(rs, 1'b0, we, p, a, d), 4);
      applyModel(rs, we, p, a, d);
      check($sformatf("R2/R4/R6/R7/R9 vec%0d regs", v), regFlat, modelFlat());
      check($sformatf("R8 vec%0d clken", v), FW'(phyClkEn), FW'(model[6][2]));
    end

    // R3: data changes while clock bit stays high must not be written
    putWord(mkWord(1'b1, 1'b0, 1'b1, 3'd0, 8'd1, 8'hAA), 4);
    putWord(mkWord(1'b1, 1'b1, 1'b1, 3'd0, 8'd1, 8'hAA), 4);
    putWord(mkWord(1'b1, 1'b1, 1'b1, 3'd0, 8'd1, 8'hBB), 6);
    applyModel(1'b1, 1'b1, 3'd0, 8'd1, 8'hAA);
    check("R3 held high", regFlat, modelFlat());
    putWord(mkWord(1'b1, 1'b0, 1'b1, 3'd0, 8'd1, 8'hBB), 4);
    check("R3 falling edge", regFlat, modelFlat());

    // R5: test reset low clears everything and blocks the write
    check("R5 precondition", FW'(phyClkEn), FW'(1));
    putWord(mkWord(1'b0, 1'b0, 1'b1, 3'd0, 8'd2, 8'h66), 4);
    check("R5 cleared", regFlat, '0);
    putWord(mkWord(1'b0, 1'b1, 1'b1, 3'd0, 8'd2, 8'h66), 4);
    putWord(mkWord(1'b0, 1'b0, 1'b1, 3'd0, 8'd2, 8'h66), 4);
    check("R5 no write", regFlat, '0);
    check("R5 clken", FW'(phyClkEn), FW'(0));
    for (int i = 0; i < NP*NR; i++) model[i] = 8'h00;

    // R5: release and write again works
    putWord(mkWord(1'b1, 1'b0, 1'b1, 3'd0, 8'd6, 8'h04), 4);
    putWord(mkWord(1'b1, 1'b1, 1'b1, 3'd0, 8'd6, 8'h04), 4);
    putWord(mkWord(1'b1, 1'b0, 1'b1, 3'd0, 8'd6, 8'h04), 4);
    applyModel(1'b1, 1'b1, 3'd0, 8'd6, 8'h04);
    check("R5 after release", regFlat, modelFlat());

    // R1: system reset clears
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    check("R1 reset again", regFlat, '0);

    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule